// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is a host-side controller for an external 16-bit bus whose pins carry first an address and then data. A host presents one 32-bit read or write at a time. The block splits it into two 16-bit bus transfers: the lower halfword goes first, then the upper. For each transfer it drives four active-low strobes: chip select, address valid, output enable and write enable. It also drives a tri-state enable for the shared pins and, when asked, a divided bus clock.

Every strobe edge is set by a programmable step count measured from the start of a transfer. A granularity option makes each step two functional-clock cycles. A half-cycle option shifts the address-valid edges onto the falling clock edge. Reads can be sampled directly on the functional clock. They can also be sampled through a two-stage path: first at the bus-clock edge, then at the programmed access step. The host sees a one-cycle ready pulse when both transfers are done, and read data comes back with it.

Top module: `adbus_master`

## Requirements
- R1: After reset and while idle, chip select, address valid, output enable and write enable are high, the pin-drive enable is low and the host ready is low.
- R2: A strobe is low for the steps s with on <= s < off, counted from 0 at the start of each transfer. It therefore falls (on - cs_on) steps after chip select and stays low for (off - on) steps.
- R3: Chip select and address valid take their deassert step from the read field on reads and from the write field on writes. Output enable pulses only on reads, and write enable pulses only on writes.
- R4: A transfer lasts cycle-time steps (read or write field) and the second transfer starts in the step right after it. The first transfer carries bus address {host address, 0} with the lower data half. The second carries {host address, 1} with the upper half.
- R5: With granularity set, every step lasts two functional-clock cycles, which doubles every pulse width and period.
- R6: With the half-cycle option set, both address-valid edges occur half a functional cycle after their programmed position. No other pin moves.
- R7: The pins are driven with the bus address while the step is below the address-valid deassert step (one more when the half-cycle option is set). Writes then drive the data half, and reads release the pins.
- R8: In asynchronous read mode, the pins are sampled at the read access step of each transfer, and the response is {upper half, lower half}.
- R9: The divider field (0 to 2) gives a bus clock of period (field + 1) functional cycles during an access. In synchronous read mode, data is taken at the bus-clock edge and then moved at the access step, which returns the same halfwords.
- R10: The host ready is a one-cycle pulse that rises 2 x cycle-time x step-length - 1 cycles after chip select first falls (when chip select is programmed to assert at step 0). The read response is valid with it.
- R11: The block never drives the shared pins while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | host request present, held until ready |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | host word address |
| req_wdata | input | 32 | write data |
| req_ready | output | 1 | one-cycle completion pulse |
| rsp_rdata | output | 32 | read response |
| cfg_cs_on | input | CNT_W | chip select assert step |
| cfg_cs_rd_off | input | CNT_W | chip select deassert step, reads |
| cfg_cs_wr_off | input | CNT_W | chip select deassert step, writes |
| cfg_adv_on | input | CNT_W | address valid assert step |
| cfg_adv_rd_off | input | CNT_W | address valid deassert step, reads |
| cfg_adv_wr_off | input | CNT_W | address valid deassert step, writes |
| cfg_oe_on | input | CNT_W | output enable assert step |
| cfg_oe_off | input | CNT_W | output enable deassert step |
| cfg_we_on | input | CNT_W | write enable assert step |
| cfg_we_off | input | CNT_W | write enable deassert step |
| cfg_rd_cycle | input | CNT_W | read transfer length in steps |
| cfg_wr_cycle | input | CNT_W | write transfer length in steps |
| cfg_rd_access | input | CNT_W | read sampling step |
| cfg_gran2 | input | 1 | two cycles per step |
| cfg_adv_half | input | 1 | half-cycle address-valid delay |
| cfg_sync_rd | input | 1 | synchronous read capture |
| cfg_clk_div | input | 2 | bus clock divider field |
| bus_cs_n | output | 1 | chip select |
| bus_adv_n | output | 1 | address valid |
| bus_oe_n | output | 1 | output enable |
| bus_we_n | output | 1 | write enable |
| bus_clk | output | 1 | bus clock |
| bus_ad_out | output | BUS_W | shared pin output value |
| bus_ad_oe | output | 1 | shared pin drive enable |
| bus_ad_in | input | BUS_W | shared pin input value |

## Verification
The bench builds the block with its defaults: 5-bit step counters, a 16-bit bus and a 15-bit host address. With these, the read and write cycle times of 9 and 7 steps fit comfortably, and the granularity option stretches them to 18 and 14 cycles without hitting the counter limit. The three divider settings 0, 1 and 2 are each used for a synchronous read. The 15-bit host address fills the 16 pins exactly once the half-select bit is appended, so the address phase can be checked bit for bit against a small memory model attached to the pins.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_BUSY = 2'd1, S_ACK = 2'd2} adbus_st_t;
  localparam int NSTB  = 4;
  localparam int IX_CS = 0;
  localparam int IX_AV = 1;
  localparam int IX_OE = 2;
  localparam int IX_WE = 3;
endpackage

// File: rtl/adbus_tick.sv
module adbus_tick #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             gran2,
  input  logic [CNT_W-1:0] lim,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             last
);
  logic ph;

  assign tick = run && (!gran2 || ph);
  assign last = tick && (({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, lim});

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else begin
      ph <= gran2 ? ~ph : 1'b0;
      if (tick) cnt <= last ? '0 : cnt + CNT_W'(1);
    end
  end

  // step counter never reaches the programmed transfer length
  assert_step_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    (run && lim != '0) |-> (cnt < lim));
endmodule

// File: rtl/adbus_strobe.sv
module adbus_strobe #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] on_step,
  input  logic [CNT_W-1:0] off_step,
  output logic             act_n
);
  always_ff @(posedge clk) begin
    if (rst) act_n <= 1'b1;
    else     act_n <= !(en && cnt >= on_step && cnt < off_step);
  end
endmodule

// File: rtl/adbus_clkdiv.sv
module adbus_clkdiv #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             bclk_q,
  output logic             edge_en
);
  logic [DIV_W-1:0] dcnt;

  assign edge_en = run && (dcnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt   <= '0;
      bclk_q <= 1'b0;
    end else begin
      bclk_q <= edge_en;
      if (!run)              dcnt <= '0;
      else if (dcnt >= div)  dcnt <= '0;
      else                   dcnt <= dcnt + DIV_W'(1);
    end
  end

  // a divided bus clock is high for exactly one functional cycle
  assert_bclk_high_one_R9: assert property (@(posedge clk) disable iff (rst)
    (run && div != '0 && bclk_q) |=> !bclk_q);
endmodule

// File: rtl/adbus_capture.sv
module adbus_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_mode,
  input  logic          bus_edge,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] samp
);
  logic [DW-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst)           stage1 <= '0;
    else if (bus_edge) stage1 <= din;
  end

  assign samp = sync_mode ? stage1 : din;
endmodule

// File: rtl/adbus_master.sv
module adbus_master
  import adbus_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic [31:0]       rsp_rdata,
  input  logic [CNT_W-1:0]  cfg_cs_on,
  input  logic [CNT_W-1:0]  cfg_cs_rd_off,
  input  logic [CNT_W-1:0]  cfg_cs_wr_off,
  input  logic [CNT_W-1:0]  cfg_adv_on,
  input  logic [CNT_W-1:0]  cfg_adv_rd_off,
  input  logic [CNT_W-1:0]  cfg_adv_wr_off,
  input  logic [CNT_W-1:0]  cfg_oe_on,
  input  logic [CNT_W-1:0]  cfg_oe_off,
  input  logic [CNT_W-1:0]  cfg_we_on,
  input  logic [CNT_W-1:0]  cfg_we_off,
  input  logic [CNT_W-1:0]  cfg_rd_cycle,
  input  logic [CNT_W-1:0]  cfg_wr_cycle,
  input  logic [CNT_W-1:0]  cfg_rd_access,
  input  logic              cfg_gran2,
  input  logic              cfg_adv_half,
  input  logic              cfg_sync_rd,
  input  logic [1:0]        cfg_clk_div,
  output logic              bus_cs_n,
  output logic              bus_adv_n,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic              bus_clk,
  output logic [BUS_W-1:0]  bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [BUS_W-1:0]  bus_ad_in
);
  localparam int HOST_W = 2 * BUS_W;
  localparam int HA_W   = ADDR_W + 1;

  adbus_st_t         st;
  logic              half_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [HOST_W-1:0] wdata_q;
  logic [BUS_W-1:0]  rd_lo, rd_hi, samp;
  logic              busy, tick, last, bus_edge, bclk_q, take, addr_phase;
  logic [CNT_W-1:0]  cnt, cyc_lim, adv_off_sel;
  logic [HA_W-1:0]   half_addr;
  logic              adv_neg;
  logic [CNT_W-1:0]  on_v  [NSTB];
  logic [CNT_W-1:0]  off_v [NSTB];
  logic              en_v  [NSTB];
  logic              stb_n [NSTB];

  assign busy        = (st == S_BUSY);
  assign cyc_lim     = we_q ? cfg_wr_cycle : cfg_rd_cycle;
  assign adv_off_sel = we_q ? cfg_adv_wr_off : cfg_adv_rd_off;
  assign half_addr   = {addr_q, half_q};
  assign take        = busy && tick && (cnt == cfg_rd_access) && !we_q;
  assign addr_phase  = ({1'b0, cnt} < ({1'b0, adv_off_sel} + {{CNT_W{1'b0}}, cfg_adv_half}));

  adbus_tick #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst(rst), .run(busy), .gran2(cfg_gran2), .lim(cyc_lim),
    .cnt(cnt), .tick(tick), .last(last));

  adbus_clkdiv #(.DIV_W(2)) u_div (
    .clk(clk), .rst(rst), .run(busy), .div(cfg_clk_div),
    .bclk_q(bclk_q), .edge_en(bus_edge));

  adbus_capture #(.DW(BUS_W)) u_cap (
    .clk(clk), .rst(rst), .sync_mode(cfg_sync_rd), .bus_edge(bus_edge),
    .din(bus_ad_in), .samp(samp));

  always_comb begin
    on_v[IX_CS]  = cfg_cs_on;
    off_v[IX_CS] = we_q ? cfg_cs_wr_off : cfg_cs_rd_off;
    en_v[IX_CS]  = busy;
    on_v[IX_AV]  = cfg_adv_on;
    off_v[IX_AV] = adv_off_sel;
    en_v[IX_AV]  = busy;
    on_v[IX_OE]  = cfg_oe_on;
    off_v[IX_OE] = cfg_oe_off;
    en_v[IX_OE]  = busy && !we_q;
    on_v[IX_WE]  = cfg_we_on;
    off_v[IX_WE] = cfg_we_off;
    en_v[IX_WE]  = busy && we_q;
  end

  for (genvar i = 0; i < NSTB; i++) begin : g_stb
    adbus_strobe #(.CNT_W(CNT_W)) u_stb (
      .clk(clk), .rst(rst), .en(en_v[i]), .cnt(cnt),
      .on_step(on_v[i]), .off_step(off_v[i]), .act_n(stb_n[i]));
  end

  always_ff @(negedge clk) begin
    if (rst) adv_neg <= 1'b1;
    else     adv_neg <= stb_n[IX_AV];
  end

  assign bus_cs_n  = stb_n[IX_CS];
  assign bus_adv_n = cfg_adv_half ? adv_neg : stb_n[IX_AV];
  assign bus_oe_n  = stb_n[IX_OE];
  assign bus_we_n  = stb_n[IX_WE];
  assign bus_clk   = (cfg_clk_div == 2'd0) ? clk : bclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ad_oe  <= 1'b0;
      bus_ad_out <= '0;
    end else begin
      bus_ad_oe  <= busy && (addr_phase || we_q);
      if (addr_phase) bus_ad_out <= BUS_W'(half_addr);
      else            bus_ad_out <= half_q ? wdata_q[HOST_W-1:BUS_W] : wdata_q[BUS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      half_q    <= 1'b0;
      we_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rd_lo     <= '0;
      rd_hi     <= '0;
      req_ready <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (take) begin
        if (half_q) rd_hi <= samp;
        else        rd_lo <= samp;
      end
      case (st)
        S_IDLE: begin
          req_ready <= 1'b0;
          if (req_valid) begin
            st      <= S_BUSY;
            half_q  <= 1'b0;
            we_q    <= req_we;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
          end
        end
        S_BUSY: begin
          if (last) begin
            if (!half_q) begin
              half_q <= 1'b1;
            end else begin
              st        <= S_ACK;
              req_ready <= 1'b1;
              rsp_rdata <= {rd_hi, rd_lo};
            end
          end
        end
        default: begin
          st        <= S_IDLE;
          req_ready <= 1'b0;
        end
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |=> (bus_cs_n && bus_oe_n && bus_we_n && !bus_ad_oe));

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  assert_no_contention_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> !bus_ad_oe);

  assert_oe_we_apart_R3: assert property (@(posedge clk) disable iff (rst)
    !(!bus_oe_n && !bus_we_n));

  always_ff @(posedge clk) begin
    if (!rst) begin
      assert_div_legal_R9: assert (cfg_clk_div <= 2'd2)
        else $error("divider field out of range");
    end
  end
endmodule

// File: tb/sim_adbus_master.sv
`timescale 1ns/1ps
module sim_adbus_master;
  localparam int CNT_W = 5;
  localparam int BUS_W = 16;
  localparam int ADDR_W = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready;
  logic [31:0] rsp_rdata;
  logic [CNT_W-1:0] cs_on, cs_rd_off, cs_wr_off, adv_on, adv_rd_off, adv_wr_off;
  logic [CNT_W-1:0] oe_on, oe_off, we_on, we_off, rd_cycle, wr_cycle, rd_access;
  logic gran2, adv_half, sync_rd;
  logic [1:0] clk_div;
  logic bus_cs_n, bus_adv_n, bus_oe_n, bus_we_n, bus_clk, bus_ad_oe;
  logic [BUS_W-1:0] bus_ad_out, bus_ad_in;

  always #10 clk = ~clk;

  adbus_master #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .cfg_cs_on(cs_on), .cfg_cs_rd_off(cs_rd_off), .cfg_cs_wr_off(cs_wr_off),
    .cfg_adv_on(adv_on), .cfg_adv_rd_off(adv_rd_off), .cfg_adv_wr_off(adv_wr_off),
    .cfg_oe_on(oe_on), .cfg_oe_off(oe_off), .cfg_we_on(we_on), .cfg_we_off(we_off),
    .cfg_rd_cycle(rd_cycle), .cfg_wr_cycle(wr_cycle), .cfg_rd_access(rd_access),
    .cfg_gran2(gran2), .cfg_adv_half(adv_half), .cfg_sync_rd(sync_rd), .cfg_clk_div(clk_div),
    .bus_cs_n(bus_cs_n), .bus_adv_n(bus_adv_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_clk(bus_clk), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in));

  int n_chk = 0, n_err = 0;
  logic [15:0] mem [64];
  logic [15:0] lat = '0, wd = '0;
  logic [31:0] exp_wr[$], exp_rd[$];
  logic cur_we = 1'b0;

  assign bus_ad_in = bus_oe_n ? 16'h0000 : mem[lat[5:0]];

  int cyc = 0;
  int csf_n, csr_n, avf_n, avr_n, oef_n, oer_n, wef_n, wer_n, bc_n, avn_n, clash, ready_t;
  int cs_f[2], cs_r[2], bc_t[2];
  int av_f, av_r, oe_f, oe_r, we_f, we_r, avn_f;
  logic p_cs = 1'b1, p_av = 1'b1, p_oe = 1'b1, p_we = 1'b1, p_bc = 1'b0, p_avn = 1'b1;

  function automatic logic [15:0] pat(input int i);
    return 16'(16'hC3A0 ^ (i * 37));
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_ev();
    csf_n = 0; csr_n = 0; avf_n = 0; avr_n = 0; oef_n = 0; oer_n = 0;
    wef_n = 0; wer_n = 0; bc_n = 0; avn_n = 0; clash = 0; ready_t = 0;
  endtask

  // monitor: memory model on the pins plus scoreboard comparison
  initial begin
    forever begin
      @(posedge clk); #2;
      cyc++;
      if (!bus_adv_n && bus_ad_oe) lat = bus_ad_out;
      if (!bus_we_n) wd = bus_ad_out;
      if (bus_we_n && !p_we) begin
        mem[lat[5:0]] = wd;
        if (exp_wr.size() == 0) check("R4", "unexpected bus write", {lat, wd}, 0);
        else check("R7", "bus write addr/data", {lat, wd}, exp_wr.pop_front());
      end
      if (req_ready) begin
        ready_t = cyc;
        if (!cur_we) begin
          if (exp_rd.size() == 0) check("R8", "unexpected read response", rsp_rdata, 0);
          else check("R8", "read response", rsp_rdata, exp_rd.pop_front());
        end
      end
      if (!bus_cs_n && p_cs) begin if (csf_n < 2) cs_f[csf_n] = cyc; csf_n++; end
      if (bus_cs_n && !p_cs) begin if (csr_n < 2) cs_r[csr_n] = cyc; csr_n++; end
      if (!bus_adv_n && p_av) begin if (avf_n == 0) av_f = cyc; avf_n++; end
      if (bus_adv_n && !p_av) begin if (avr_n == 0) av_r = cyc; avr_n++; end
      if (!bus_oe_n && p_oe) begin if (oef_n == 0) oe_f = cyc; oef_n++; end
      if (bus_oe_n && !p_oe) begin if (oer_n == 0) oe_r = cyc; oer_n++; end
      if (!bus_we_n && p_we) begin if (wef_n == 0) we_f = cyc; wef_n++; end
      if (bus_we_n && !p_we) begin if (wer_n == 0) we_r = cyc; wer_n++; end
      if (clk_div != 2'd0 && bus_clk && !p_bc) begin if (bc_n < 2) bc_t[bc_n] = cyc; bc_n++; end
      if (!bus_oe_n && bus_ad_oe) clash++;
      p_cs = bus_cs_n; p_av = bus_adv_n; p_oe = bus_oe_n; p_we = bus_we_n;
      p_bc = (clk_div != 2'd0) ? bus_clk : 1'b0;
    end
  end

  initial begin
    forever begin
      @(negedge clk); #2;
      if (!bus_adv_n && p_avn) begin if (avn_n == 0) avn_f = cyc; avn_n++; end
      p_avn = bus_adv_n;
    end
  end

  task automatic set_default();
    cs_on = 0; cs_rd_off = 7; cs_wr_off = 6;
    adv_on = 1; adv_rd_off = 3; adv_wr_off = 2;
    oe_on = 4; oe_off = 8; we_on = 3; we_off = 5;
    rd_cycle = 9; wr_cycle = 7; rd_access = 7;
    gran2 = 0; adv_half = 0; sync_rd = 0; clk_div = 0;
  endtask

  // driver: queue expected items, run one host access
  task automatic access(input logic we, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    if (we) begin
      exp_wr.push_back({{a, 1'b0}, d[15:0]});
      exp_wr.push_back({{a, 1'b1}, d[31:16]});
    end else begin
      exp_rd.push_back({mem[{a[4:0], 1'b1}], mem[{a[4:0], 1'b0}]});
    end
    clear_ev();
    @(negedge clk);
    cur_we = we; req_we = we; req_addr = a; req_wdata = d; req_valid = 1'b1;
    forever begin
      @(posedge clk); #2;
      if (req_ready) break;
    end
    req_valid = 1'b0;
    repeat (4) @(posedge clk);
    #3;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = pat(i);
    set_default();
    repeat (3) @(posedge clk);
    #2;
    check("R1", "cs_n in reset", bus_cs_n, 1);
    check("R1", "adv/oe/we in reset", {bus_adv_n, bus_oe_n, bus_we_n}, 3'b111);
    check("R1", "pin drive in reset", bus_ad_oe, 0);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(posedge clk); #2;
    check("R1", "idle ready low", req_ready, 0);
    check("R1", "idle strobes high", {bus_cs_n, bus_adv_n, bus_oe_n, bus_we_n}, 4'hF);

    // write, step length 1
    access(1'b1, 15'd5, 32'hBEEF_1234);
    check("R3", "write cs width", cs_r[0] - cs_f[0], 6);
    check("R4", "write transfer spacing", cs_f[1] - cs_f[0], 7);
    check("R4", "two transfers", csf_n, 2);
    check("R2", "adv offset from cs", av_f - cs_f[0], 1);
    check("R3", "write adv width", av_r - av_f, 1);
    check("R2", "we width", we_r - we_f, 2);
    check("R2", "we offset from cs", we_f - cs_f[0], 3);
    check("R3", "no oe on write", oef_n, 0);
    check("R10", "write ready latency", ready_t - cs_f[0], 13);

    // async read back
    access(1'b0, 15'd5, 32'h0);
    check("R3", "read cs width", cs_r[0] - cs_f[0], 7);
    check("R4", "read transfer spacing", cs_f[1] - cs_f[0], 9);
    check("R3", "read adv width", av_r - av_f, 2);
    check("R2", "oe width", oe_r - oe_f, 4);
    check("R2", "oe offset from cs", oe_f - cs_f[0], 4);
    check("R3", "no we on read", wef_n, 0);
    check("R10", "read ready latency", ready_t - cs_f[0], 17);
    check("R11", "no drive while oe low", clash, 0);

    // async read of preloaded data
    access(1'b0, 15'd20, 32'h0);
    check("R7", "pins released in read", clash, 0);

    // granularity two
    gran2 = 1;
    access(1'b1, 15'd6, 32'h5A5A_0FF0);
    check("R5", "gran2 cs width", cs_r[0] - cs_f[0], 12);
    check("R5", "gran2 spacing", cs_f[1] - cs_f[0], 14);
    check("R5", "gran2 adv offset", av_f - cs_f[0], 2);
    check("R5", "gran2 ready latency", ready_t - cs_f[0], 27);
    gran2 = 0;

    // half-cycle address valid
    adv_half = 1;
    access(1'b1, 15'd7, 32'h1357_9BDF);
    check("R6", "adv late at rising-edge sample", av_f - cs_f[0], 2);
    check("R6", "adv fell by falling-edge sample", avn_f - cs_f[0], 1);
    check("R6", "cs width unchanged", cs_r[0] - cs_f[0], 6);
    adv_half = 0;

    // synchronous reads at three divider settings
    sync_rd = 1; clk_div = 2;
    access(1'b0, 15'd6, 32'h0);
    check("R9", "bus clock period div2", bc_t[1] - bc_t[0], 3);
    clk_div = 1;
    access(1'b0, 15'd7, 32'h0);
    check("R9", "bus clock period div1", bc_t[1] - bc_t[0], 2);
    clk_div = 0;
    access(1'b0, 15'd20, 32'h0);
    check("R9", "sync read div0 ready latency", ready_t - cs_f[0], 17);
    sync_rd = 0;

    check("R8", "read queue drained", exp_rd.size(), 0);
    check("R4", "write queue drained", exp_wr.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule